// File: doc/BRIEF.md
# Block Address Mapper with Map Image Swap

This block sits between a 16-bit processor and a larger physical memory. It cuts the logical space into sixteen 4 KB blocks. The top four logical address bits pick one map entry. That entry's 24-bit base is added, with full carry, to the twelve low logical bits to form a 24-bit physical address. Each mapped access costs one added wait state. In that state the upper half of the physical address leaves on a shared 12-bit address bus. The lower half follows in the cycle when the processor is released.

Each entry also carries three protection flags: write, execute and read. A forbidden read or instruction fetch still completes, but it raises a level interrupt. A forbidden write is suppressed by holding write-enable inactive. Two regions are exempt from protection: the window that holds the map images and the control address.

Writing the control address selects one of eight 64-byte images kept in an external static RAM. The block then requests the processor bus. Once the bus is granted, it copies that image into the internal map, or copies the map out to the image.

Top module: `blkmap_top`

## Requirements
- R1: The physical address is {entry base} + logical[11:0] over 24 bits with full carry. The entry is selected by logical[15:12]. After reset every base is zero, so the physical address equals the logical address.
- R2: An access request taken in state IDLE moves the machine to WAIT_HI for one cycle. In WAIT_HI, cpu_ready is 0, pa_upper is 1 and pa_bus carries physical[23:12]. The machine then moves to XFER_LO for one cycle. In XFER_LO, cpu_ready is 1, pa_upper is 0 and pa_bus carries physical[11:0]. It then returns to IDLE.
- R3: Entry e occupies image bytes 4e..4e+3 as two 16-bit words. The first word holds base[23:16] in bits 7:0, the write-protect flag in bit 8, the execute-protect flag in bit 9 and the read-protect flag in bit 10. The second word holds base[15:0].
- R4: A write to CTRL_ADDR (default 0xF200) latches cpu_wdata[2:0] as the image index and cpu_wdata[3] as the direction (1 = load map, 0 = save map). It then moves XFER_LO to BUS_REQ, where hold is asserted. No image transfer starts until holda is 1, which moves BUS_REQ to MOVE.
- R5: A load issues 32 word reads in ascending order at IMG_BASE + 64*index + 2*w, for w = 0..31. The data read replaces the internal map.
- R6: A save issues 32 word writes in ascending order at the same addresses, carrying the current map words.
- R7: A data read to a read-protected block, or an instruction fetch to an execute-protected block, still receives cpu_ready. prot_irq is set after XFER_LO. Execute protection does not affect data reads.
- R8: A write to a write-protected block keeps we_n at 1 in XFER_LO and sets prot_irq. An allowed write drives we_n to 0 in XFER_LO only.
- R9: prot_irq stays at 1 until a control write clears it, at the same edge where hold rises.
- R10: Accesses inside the image window (IMG_BASE .. IMG_BASE+511, default 0xF000..0xF1FF) and to CTRL_ADDR ignore all protection flags.
- R11: After reset, hold is 0, prot_irq is 0, we_n is 1 and cpu_ready is 0.
- R12: While hold is asserted, cpu_req is ignored. cpu_ready stays 0 and we_n stays 1. After the last word, MOVE goes to RELEASE (hold 0) and then to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | One-cycle access request |
| cpu_wr | input | 1 | Request is a write |
| cpu_fetch | input | 1 | Request is an instruction fetch |
| cpu_addr | input | 16 | Logical address |
| cpu_wdata | input | 16 | Write data (control byte in bits 3:0) |
| cpu_ready | output | 1 | Access completes this cycle |
| pa_bus | output | 12 | Multiplexed physical address |
| pa_upper | output | 1 | pa_bus carries the upper half |
| we_n | output | 1 | Memory write enable, active low |
| prot_irq | output | 1 | Protection violation interrupt level |
| hold | output | 1 | Bus request to the processor |
| holda | input | 1 | Bus grant from the processor |
| dma_addr | output | 16 | Image RAM word address (byte address) |
| dma_rd | output | 1 | Image RAM read strobe |
| dma_wr | output | 1 | Image RAM write strobe |
| dma_wdata | output | 16 | Image RAM write data |
| dma_rdata | input | 16 | Image RAM read data, valid the cycle after dma_rd |

## Verification
A wrong map word shows up on pa_bus within two cycles of the next request to that block. The upper half appears in WAIT_HI and the lower half in XFER_LO, and a misplaced flag appears as a wrong we_n or prot_irq in the same access. A miscounted or misindexed transfer shows at once as an out-of-order dma_addr or a wrong strobe count. A slipped capture only becomes visible later, when an access is translated or a later save writes the stored map back, so every save is compared word for word with the bench's map model. A stuck state shows up as a hold that never drops or a missing cpu_ready, caught within a few cycles.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_HI,
        S_XFER_LO,
        S_BUS_REQ,
        S_MOVE,
        S_RELEASE
    } map_state_t;

    localparam int unsigned FLAG_WP = 8;
    localparam int unsigned FLAG_XP = 9;
    localparam int unsigned FLAG_RP = 10;
endpackage

// File: rtl/blkmap_store.sv
module blkmap_store #(
    parameter int unsigned BLK_W  = 4,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned WORDS = 2 * (2 ** BLK_W),
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  lk_blk,
    output logic [WORD_W-1:0] lk_w0,
    output logic [WORD_W-1:0] lk_w1,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] words_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(WORDS); i++) begin
                words_q[i] <= '0;
            end
        end else if (wr_en) begin
            words_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        lk_w0   = words_q[{lk_blk, 1'b0}];
        lk_w1   = words_q[{lk_blk, 1'b1}];
        rd_data = words_q[rd_idx];
    end
endmodule

// File: rtl/blkmap_xlate.sv
module blkmap_xlate
    import blkmap_pkg::*;
#(
    parameter int unsigned PA_W  = 24,
    parameter int unsigned OFF_W = 12,
    localparam int unsigned HI_W = PA_W - 16
) (
    input  logic [15:0]      w0,
    input  logic [15:0]      w1,
    input  logic [OFF_W-1:0] offset,
    input  logic             is_wr,
    input  logic             is_fetch,
    output logic [PA_W-1:0]  phys,
    output logic             viol
);
    logic [PA_W-1:0] base;
    logic            unused_rsv;

    always_comb begin
        base       = {w0[HI_W-1:0], w1};
        phys       = base + PA_W'(offset);
        unused_rsv = ^w0[15:FLAG_RP+1];
        if (is_wr) begin
            viol = w0[FLAG_WP];
        end else if (is_fetch) begin
            viol = w0[FLAG_XP];
        end else begin
            viol = w0[FLAG_RP];
        end
    end
endmodule

// File: rtl/blkmap_ctrl.sv
module blkmap_ctrl
    import blkmap_pkg::*;
#(
    parameter int unsigned LA_W      = 16,
    parameter int unsigned N_IMG     = 8,
    parameter int unsigned WORDS     = 32,
    parameter int unsigned IMG_BASE  = 16'hF000,
    parameter int unsigned CTRL_ADDR = 16'hF200,
    localparam int unsigned IDX_W    = $clog2(N_IMG),
    localparam int unsigned CNT_W    = $clog2(WORDS),
    localparam int unsigned WIN_SIZE = N_IMG * WORDS * 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_wr,
    input  logic             cpu_fetch,
    input  logic [LA_W-1:0]  cpu_addr,
    input  logic [IDX_W:0]   cpu_ctl,
    input  logic             viol,
    input  logic             holda,
    output logic [LA_W-1:0]  addr_q,
    output logic             wr_q,
    output logic             fetch_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             map_we,
    output logic             cpu_ready,
    output logic             pa_upper,
    output logic             we_n,
    output logic             prot_irq,
    output logic             hold,
    output logic [LA_W-1:0]  dma_addr,
    output logic             dma_rd,
    output logic             dma_wr
);
    map_state_t       state_q, state_d;
    logic [IDX_W:0]   ctl_q;
    logic [IDX_W-1:0] img_q;
    logic             dir_q;
    logic             ph_q;
    logic             irq_q;
    logic [LA_W-1:0]  rel;
    logic             is_ctrl, in_win, bypass, ctrl_wr;

    always_comb begin
        rel     = addr_q - LA_W'(IMG_BASE);
        in_win  = (addr_q >= LA_W'(IMG_BASE)) && (rel < LA_W'(WIN_SIZE));
        is_ctrl = (addr_q == LA_W'(CTRL_ADDR));
        bypass  = in_win || is_ctrl;
        ctrl_wr = is_ctrl && wr_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (cpu_req) state_d = S_WAIT_HI;
            S_WAIT_HI: state_d = S_XFER_LO;
            S_XFER_LO: state_d = ctrl_wr ? S_BUS_REQ : S_IDLE;
            S_BUS_REQ: if (holda) state_d = S_MOVE;
            S_MOVE:    if (ph_q && (cnt_q == CNT_W'(WORDS - 1))) state_d = S_RELEASE;
            S_RELEASE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            fetch_q <= 1'b0;
            ctl_q   <= '0;
            img_q   <= '0;
            dir_q   <= 1'b0;
            cnt_q   <= '0;
            ph_q    <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (cpu_req) begin
                    addr_q  <= cpu_addr;
                    wr_q    <= cpu_wr;
                    fetch_q <= cpu_fetch && !cpu_wr;
                    ctl_q   <= cpu_ctl;
                end
                S_XFER_LO: begin
                    if (ctrl_wr) begin
                        img_q <= ctl_q[IDX_W-1:0];
                        dir_q <= ctl_q[IDX_W];
                        irq_q <= 1'b0;
                    end else if (viol && !bypass) begin
                        irq_q <= 1'b1;
                    end
                end
                S_BUS_REQ: begin
                    cnt_q <= '0;
                    ph_q  <= 1'b0;
                end
                S_MOVE: begin
                    ph_q <= !ph_q;
                    if (ph_q) cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        pa_upper  = (state_q == S_WAIT_HI);
        cpu_ready = (state_q == S_XFER_LO);
        we_n      = !(cpu_ready && wr_q && (bypass || !viol));
        hold      = (state_q == S_BUS_REQ) || (state_q == S_MOVE);
        prot_irq  = irq_q;
        dma_addr  = LA_W'(IMG_BASE) + LA_W'({img_q, cnt_q, 1'b0});
        dma_rd    = (state_q == S_MOVE) && !ph_q && dir_q;
        dma_wr    = (state_q == S_MOVE) && !ph_q && !dir_q;
        map_we    = (state_q == S_MOVE) && ph_q && dir_q;
    end
endmodule

// File: rtl/blkmap_top.sv
module blkmap_top #(
    parameter int unsigned LA_W      = 16,
    parameter int unsigned PA_W      = 24,
    parameter int unsigned BLK_W     = 4,
    parameter int unsigned N_IMG     = 8,
    parameter int unsigned IMG_BASE  = 16'hF000,
    parameter int unsigned CTRL_ADDR = 16'hF200,
    localparam int unsigned OFF_W    = LA_W - BLK_W,
    localparam int unsigned WORDS    = 2 * (2 ** BLK_W),
    localparam int unsigned CNT_W    = $clog2(WORDS),
    localparam int unsigned IDX_W    = $clog2(N_IMG),
    localparam int unsigned HALF_W   = PA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic              cpu_fetch,
    input  logic [LA_W-1:0]   cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic [HALF_W-1:0] pa_bus,
    output logic              pa_upper,
    output logic              we_n,
    output logic              prot_irq,
    output logic              hold,
    input  logic              holda,
    output logic [LA_W-1:0]   dma_addr,
    output logic              dma_rd,
    output logic              dma_wr,
    output logic [15:0]       dma_wdata,
    input  logic [15:0]       dma_rdata
);
    logic [LA_W-1:0]  addr_q;
    logic             wr_q, fetch_q, map_we, viol;
    logic [CNT_W-1:0] cnt_q;
    logic [15:0]      lk_w0, lk_w1;
    logic [PA_W-1:0]  phys;
    logic             unused_wd;

    assign unused_wd = ^cpu_wdata[15:IDX_W+1];

    blkmap_ctrl #(
        .LA_W(LA_W), .N_IMG(N_IMG), .WORDS(WORDS),
        .IMG_BASE(IMG_BASE), .CTRL_ADDR(CTRL_ADDR)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_fetch(cpu_fetch),
        .cpu_addr(cpu_addr), .cpu_ctl(cpu_wdata[IDX_W:0]),
        .viol(viol), .holda(holda),
        .addr_q(addr_q), .wr_q(wr_q), .fetch_q(fetch_q), .cnt_q(cnt_q),
        .map_we(map_we), .cpu_ready(cpu_ready), .pa_upper(pa_upper),
        .we_n(we_n), .prot_irq(prot_irq), .hold(hold),
        .dma_addr(dma_addr), .dma_rd(dma_rd), .dma_wr(dma_wr)
    );

    blkmap_store #(.BLK_W(BLK_W), .WORD_W(16)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_blk(addr_q[LA_W-1:OFF_W]), .lk_w0(lk_w0), .lk_w1(lk_w1),
        .rd_idx(cnt_q), .rd_data(dma_wdata),
        .wr_en(map_we), .wr_idx(cnt_q), .wr_data(dma_rdata)
    );

    blkmap_xlate #(.PA_W(PA_W), .OFF_W(OFF_W)) u_xlate (
        .w0(lk_w0), .w1(lk_w1), .offset(addr_q[OFF_W-1:0]),
        .is_wr(wr_q), .is_fetch(fetch_q), .phys(phys), .viol(viol)
    );

    assign pa_bus = pa_upper ? phys[PA_W-1:HALF_W] : phys[HALF_W-1:0];
endmodule

// File: rtl/blkmap_chk.sv
module blkmap_chk (
    input logic clk,
    input logic rst_n,
    input logic pa_upper,
    input logic cpu_ready,
    input logic we_n,
    input logic hold,
    input logic holda,
    input logic dma_rd,
    input logic dma_wr,
    input logic prot_irq
);
    assert_lo_follows_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pa_upper |=> (cpu_ready && !pa_upper));

    assert_ready_after_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ready) |-> $past(pa_upper));

    assert_no_move_without_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd || dma_wr) |-> (hold && holda));

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_rd && dma_wr));

    assert_write_only_on_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> cpu_ready);

    assert_irq_clears_with_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_irq) |-> $rose(hold));

    assert_cpu_shut_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!cpu_ready && we_n));
endmodule

bind blkmap_top blkmap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pa_upper(pa_upper), .cpu_ready(cpu_ready),
    .we_n(we_n), .hold(hold), .holda(holda), .dma_rd(dma_rd),
    .dma_wr(dma_wr), .prot_irq(prot_irq)
);

// File: tb/blkmap_top_tb.sv
module blkmap_top_tb;
    localparam logic [15:0] IMG_BASE  = 16'hF000;
    localparam logic [15:0] CTRL_ADDR = 16'hF200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_wr = 1'b0, cpu_fetch = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, pa_upper, we_n, prot_irq, hold;
    logic        holda = 1'b0;
    logic [11:0] pa_bus;
    logic [15:0] dma_addr, dma_wdata;
    logic [15:0] dma_rdata = '0;
    logic        dma_rd, dma_wr;

    int checks = 0, errors = 0;
    logic [15:0] sram [256];
    logic [15:0] mw [32];
    logic        irq_m = 1'b0;
    int          dma_n = 0, dma_bad = 0;
    logic [2:0]  exp_img = '0;
    logic        exp_dir = 1'b0;
    logic        mon_on = 1'b0;

    always #4 clk = !clk;

    blkmap_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_fetch(cpu_fetch), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .pa_bus(pa_bus), .pa_upper(pa_upper),
        .we_n(we_n), .prot_irq(prot_irq), .hold(hold), .holda(holda),
        .dma_addr(dma_addr), .dma_rd(dma_rd), .dma_wr(dma_wr),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata)
    );

    // static RAM holding the images, one-cycle read latency
    always @(posedge clk) begin
        if (dma_rd) dma_rdata <= sram[8'((dma_addr - IMG_BASE) >> 1)];
        if (dma_wr) sram[8'((dma_addr - IMG_BASE) >> 1)] <= dma_wdata;
        if (mon_on && (dma_rd || dma_wr)) begin
            if (dma_addr != IMG_BASE + 16'(exp_img) * 16'd64 + 16'(dma_n) * 16'd2) dma_bad++;
            if (dma_rd != exp_dir) dma_bad++;
            dma_n++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_phys(input logic [15:0] a);
        logic [3:0] b;
        b = a[15:12];
        return {mw[{b, 1'b0}][7:0], mw[{b, 1'b1}]} + {12'h0, a[11:0]};
    endfunction

    function automatic logic exp_viol(input logic [15:0] a, input logic w, input logic f);
        logic [15:0] w0;
        w0 = mw[{a[15:12], 1'b0}];
        if ((a >= IMG_BASE && a < IMG_BASE + 16'd512) || a == CTRL_ADDR) return 1'b0;
        if (w) return w0[8];
        if (f) return w0[9];
        return w0[10];
    endfunction

    task automatic access(input string tag, input logic [15:0] a, input logic w,
                          input logic f, input logic [15:0] d);
        logic [23:0] p;
        logic        v;
        p = exp_phys(a);
        v = exp_viol(a, w, f);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = w; cpu_fetch = f; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        check({tag, " R2 upper flag"}, 32'(pa_upper), 32'd1);
        check({tag, " R2 wait ready"}, 32'(cpu_ready), 32'd0);
        check({tag, " R1 upper half"}, 32'(pa_bus), 32'(p[23:12]));
        @(negedge clk);
        check({tag, " R2 lo ready"}, 32'(cpu_ready), 32'd1);
        check({tag, " R1 lower half"}, 32'(pa_bus), 32'(p[11:0]));
        check({tag, " R8 we_n"}, 32'(we_n), 32'(!(w && !v)));
        @(negedge clk);
        if (w && a == CTRL_ADDR) irq_m = 1'b0;
        else if (v) irq_m = 1'b1;
        check({tag, " R7 R9 irq"}, 32'(prot_irq), 32'(irq_m));
    endtask

    task automatic swap(input logic [2:0] img, input logic dir);
        int guard;
        exp_img = img; exp_dir = dir; dma_n = 0; dma_bad = 0; mon_on = 1'b1;
        access("ctrl", CTRL_ADDR, 1'b1, 1'b0, {12'h0, dir, img});
        check("R4 hold raised", 32'(hold), 32'd1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R4 idle before grant", 32'(dma_n), 32'd0);
        end
        holda = 1'b1;
        guard = 0;
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 16'h0000;
        while (hold && guard < 200) begin
            @(negedge clk);
            guard++;
            if (hold) begin
                checks++;
                if (cpu_ready !== 1'b0 || we_n !== 1'b1) begin
                    errors++;
                    $display("FAIL R12 cpu not shut out ready=%0b we_n=%0b expected 0/1",
                             cpu_ready, we_n);
                end
            end
        end
        cpu_req = 1'b0; cpu_wr = 1'b0;
        holda = 1'b0;
        mon_on = 1'b0;
        check("R4 hold released", 32'(hold), 32'd0);
        check(dir ? "R5 word count" : "R6 word count", 32'(dma_n), 32'd32);
        check(dir ? "R5 order" : "R6 order", 32'(dma_bad), 32'd0);
        if (dir) begin
            for (int i = 0; i < 32; i++) mw[i] = sram[32 * int'(img) + i];
        end else begin
            for (int i = 0; i < 32; i++) check("R6 saved word", 32'(sram[32 * int'(img) + i]), 32'(mw[i]));
        end
    endtask

    function automatic void put_entry(input int img, input int e, input logic [2:0] prot,
                                      input logic [23:0] base);
        sram[img * 32 + e * 2]     = {5'h0, prot, base[23:16]};
        sram[img * 32 + e * 2 + 1] = base[15:0];
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 32; i++) mw[i] = '0;
        for (int img = 0; img < 8; img++) begin
            for (int e = 0; e < 16; e++) begin
                put_entry(img, e, ($urandom % 4 == 0) ? 3'($urandom) : 3'b000, 24'($urandom));
            end
        end
        // directed image 5: carry, each flag, fully protected top block (R3 layout)
        put_entry(5, 1, 3'b000, 24'h040000);
        put_entry(5, 2, 3'b000, 24'h12FFF0);
        put_entry(5, 3, 3'b001, 24'h200000);
        put_entry(5, 4, 3'b010, 24'h300000);
        put_entry(5, 5, 3'b100, 24'h400000);
        put_entry(5, 15, 3'b111, 24'hABC000);

        repeat (3) @(negedge clk);
        check("R11 hold", 32'(hold), 32'd0);
        check("R11 irq", 32'(prot_irq), 32'd0);
        check("R11 we_n", 32'(we_n), 32'd1);
        check("R11 ready", 32'(cpu_ready), 32'd0);
        rst_n = 1'b1;
        access("R11 identity", 16'h1234, 1'b0, 1'b0, 16'h0);
        access("R11 identity wr", 16'h8FFE, 1'b1, 1'b0, 16'h0);

        swap(3'd5, 1'b1);
        access("R1 carry", 16'h2020, 1'b0, 1'b0, 16'h0);
        check("R1 carry value", 32'(exp_phys(16'h2020)), 32'h130010);
        access("R8 write prot", 16'h3000, 1'b1, 1'b0, 16'h0);
        access("R9 hold level", 16'h1000, 1'b0, 1'b0, 16'h0);
        swap(3'd6, 1'b0);
        access("R7 xp data read ok", 16'h4000, 1'b0, 1'b0, 16'h0);
        access("R7 fetch prot", 16'h4010, 1'b0, 1'b1, 16'h0);
        swap(3'd7, 1'b0);
        access("R7 read prot", 16'h5000, 1'b0, 1'b0, 16'h0);
        swap(3'd6, 1'b0);
        access("R10 window write", IMG_BASE + 16'h01F0, 1'b1, 1'b0, 16'h0);
        access("R10 window fetch", IMG_BASE + 16'h0010, 1'b0, 1'b1, 16'h0);
        access("R10 outside window", 16'hF300, 1'b0, 1'b0, 16'h0);
        swap(3'd6, 1'b0);

        for (int r = 0; r < 6; r++) begin
            swap(3'(r % 5), 1'b1);
            for (int k = 0; k < 12; k++) begin
                logic [15:0] a;
                logic        w, f;
                a = {4'($urandom % 15), 12'($urandom)};
                w = ($urandom % 3 == 0);
                f = !w && ($urandom % 2 == 0);
                access("R1 random", a, w, f, 16'($urandom));
                if (irq_m) swap(3'(r % 5), 1'b0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule